// File: doc/BRIEF.md
# Reed-Solomon (255,239) Stream Encoder

This block turns a stream of 32-bit words into systematic Reed-Solomon (255,239) codewords over GF(2^8). Every word carries four 8-bit symbols. The block absorbs them into a 16-stage remainder register, most significant byte first, and forwards each information word unchanged. When the 239th information symbol arrives, the block appends the 16 parity symbols, packed into the same 32-bit lanes. One codeword leaves as 64 output words. The last of these words is flagged with `m_tlast` and is padded with one zero byte.

Word boundaries and symbol boundaries do not line up. The 60th input word therefore carries only three information symbols, in its upper three bytes, and its lowest byte is discarded. In that output word the freed lane carries the first parity byte. The remaining fifteen parity bytes follow in four more words. During those four words the input is held off. Every output word passes through a fixed pipeline of seven registers, so an accepted word leaves a fixed number of edges later unless the output stalls. Backpressure on the output freezes the whole pipeline.

The controller has two states. `S_DATA` accepts input words and counts them. Transition `DATA_TO_PARITY` fires when the 60th word is accepted. `S_PARITY` pushes the four parity words while the input is not ready. Transition `PARITY_TO_DATA` fires when the final parity word enters the pipeline. The same transition clears the remainder register for the next codeword.

Top module: `rs_stream_encoder`

## Requirements
- R1: Input words 1 to 59 of a codeword appear unchanged as output words 1 to 59. Bits 31:8 of output word 60 equal bits 31:8 of input word 60.
- R2: Symbols are taken from a word most significant byte first. Bits 7:0 of input word 60 have no effect on any output word.
- R3: Bytes 0 to 254 of the 64 output words, read most significant byte first, form a codeword c(x) with byte 0 as the coefficient of x^254. The field polynomial is x^8+x^7+x^2+x+1 and alpha is 0x02. c(alpha^i) is zero for every i from 0 to 15.
- R4: Each codeword produces exactly 64 output words. Bits 7:0 of output word 60 hold the first parity byte. Bits 7:0 of output word 64 are zero.
- R5: `m_tlast` is high on output word 64 of each codeword and low on every other output word.
- R6: After the 60th input word is accepted, with `m_tready` held high, `s_tready` is low for exactly the next four cycles.
- R7: With `m_tready` held high, a word accepted at a clock edge is transferred at the output exactly 7 edges later.
- R8: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values. No word is lost or duplicated.
- R9: The remainder register starts from zero for every codeword. An all-zero codeword sent after a non-zero one produces 64 all-zero output words.
- R10: After reset, `m_tvalid` is low and `s_tready` is high.
- R11: Gaps in `s_tvalid` do not change the content of any output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_tdata | input | 32 | Four information symbols, most significant byte first |
| s_tvalid | input | 1 | Input word valid |
| s_tready | output | 1 | Encoder accepts an input word |
| m_tdata | output | 32 | Encoded word: information, parity or pad |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Downstream accepts an output word |
| m_tlast | output | 1 | Final word of a codeword |

## Verification
The bench builds the encoder with its default parameters: 32-bit words, a (255,239) code, roots alpha^0 to alpha^15 and seven pipeline registers. These values bring within reach the three-symbol tail word and its discarded low byte, the parity byte that shares an output word with information, and the single zero pad byte in the last word. The bench evaluates the sixteen syndromes of each received codeword with its own field arithmetic. It repeats the same message with input gaps and output stalls and expects identical words. It follows a non-zero codeword with an all-zero one to expose any remainder left over from the previous codeword.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

    localparam int SYM_W = 8;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [0:0] {
        S_DATA   = 1'b0,
        S_PARITY = 1'b1
    } enc_state_e;

    typedef enum logic [1:0] {
        PK_PASS   = 2'd0,
        PK_TAIL   = 2'd1,
        PK_PARITY = 2'd2
    } pack_mode_e;

    // multiply by alpha (x) modulo the field polynomial
    function automatic sym_t gf_xtime(input sym_t a, input logic [8:0] poly);
        sym_t sh;
        sh = {a[SYM_W-2:0], 1'b0};
        return a[SYM_W-1] ? (sh ^ poly[SYM_W-1:0]) : sh;
    endfunction

    function automatic sym_t gf_mul(input sym_t a, input sym_t b, input logic [8:0] poly);
        sym_t acc;
        sym_t x;
        acc = '0;
        x   = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ x;
            x = gf_xtime(x, poly);
        end
        return acc;
    endfunction

    function automatic sym_t gf_alpha_pow(input int e, input logic [8:0] poly);
        sym_t r;
        r = 8'h01;
        for (int i = 0; i < e; i++) r = gf_xtime(r, poly);
        return r;
    endfunction

    // coefficient idx of prod_{i<nroots} (x + alpha^(first+i)), ascending degree
    function automatic sym_t gen_coef(input int idx, input int nroots, input int first,
                                      input logic [8:0] poly);
        sym_t g [0:64];
        sym_t root;
        for (int j = 0; j <= 64; j++) g[j] = '0;
        g[0] = 8'h01;
        for (int i = 0; i < nroots; i++) begin
            root = gf_alpha_pow(first + i, poly);
            for (int j = i + 1; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root, poly);
            g[0] = gf_mul(g[0], root, poly);
        end
        return g[idx];
    endfunction

endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul
    import rs_enc_pkg::*;
#(
    parameter sym_t       COEF = 8'h01,
    parameter logic [8:0] POLY = 9'h187
)(
    input  sym_t a,
    output sym_t y
);

    // eight-entry table: COEF times each basis element x^b
    sym_t term [SYM_W];

    for (genvar b = 0; b < SYM_W; b++) begin : g_basis
        localparam sym_t BASIS = gf_mul(COEF, sym_t'(1 << b), POLY);
        assign term[b] = a[b] ? BASIS : '0;
    end

    always_comb begin
        y = '0;
        for (int b = 0; b < SYM_W; b++) y = y ^ term[b];
    end

endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
    import rs_enc_pkg::*;
#(
    parameter int         NPAR       = 16,
    parameter int         LANES      = 4,
    parameter int         FIRST_ROOT = 0,
    parameter logic [8:0] POLY       = 9'h187,
    localparam int        PW         = NPAR * SYM_W,
    localparam int        NW         = $clog2(LANES + 1)
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   absorb,
    input  logic                   clr,
    input  logic [LANES*SYM_W-1:0] word_in,
    input  logic [NW-1:0]          n_use,
    output logic [PW-1:0]          par_q,
    output logic [PW-1:0]          par_next
);

    logic [PW-1:0] chain [LANES+1];

    assign chain[0] = par_q;

    for (genvar s = 0; s < LANES; s++) begin : g_step
        sym_t          sym;
        sym_t          fb;
        logic [PW-1:0] nxt;

        assign sym = word_in[(LANES-1-s)*SYM_W +: SYM_W];
        assign fb  = sym ^ chain[s][PW-1 -: SYM_W];

        for (genvar i = 0; i < NPAR; i++) begin : g_tap
            localparam sym_t COEF = gen_coef(i, NPAR, FIRST_ROOT, POLY);
            sym_t prod;
            rs_gf_cmul #(.COEF(COEF), .POLY(POLY)) u_mul (.a(fb), .y(prod));
            if (i == 0) begin : g_low
                assign nxt[SYM_W-1:0] = prod;
            end else begin : g_high
                assign nxt[i*SYM_W +: SYM_W] = chain[s][(i-1)*SYM_W +: SYM_W] ^ prod;
            end
        end

        assign chain[s+1] = (NW'(s) < n_use) ? nxt : chain[s];
    end

    assign par_next = chain[LANES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q <= '0;
        end else if (clr) begin
            par_q <= '0;
        end else if (absorb) begin
            par_q <= par_next;
        end
    end

    // R9: a cleared register starts the next codeword from zero
    a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !absorb) |=> (par_q == '0));

endmodule

// File: rtl/rs_lane_packer.sv
module rs_lane_packer
    import rs_enc_pkg::*;
#(
    parameter int  LANES     = 4,
    parameter int  NPAR      = 16,
    parameter int  TAIL_SYMS = 3,
    parameter int  IDX_W     = 2,
    localparam int FILL      = LANES - TAIL_SYMS
)(
    input  pack_mode_e             mode,
    input  logic [LANES*SYM_W-1:0] word_in,
    input  logic [NPAR*SYM_W-1:0]  par_tail,
    input  logic [NPAR*SYM_W-1:0]  par_body,
    input  logic [IDX_W-1:0]       word_idx,
    output logic [LANES*SYM_W-1:0] word_out
);

    always_comb begin
        int ti;
        int pk;
        word_out = '0;
        unique case (mode)
            PK_PASS: begin
                word_out = word_in;
            end
            PK_TAIL: begin
                for (int j = 0; j < LANES; j++) begin
                    ti = (j < TAIL_SYMS) ? 0 : (j - TAIL_SYMS);
                    if (j < TAIL_SYMS)
                        word_out[(LANES-1-j)*SYM_W +: SYM_W] = word_in[(LANES-1-j)*SYM_W +: SYM_W];
                    else
                        word_out[(LANES-1-j)*SYM_W +: SYM_W] = par_tail[(NPAR-1-ti)*SYM_W +: SYM_W];
                end
            end
            PK_PARITY: begin
                for (int j = 0; j < LANES; j++) begin
                    pk = FILL + int'(word_idx) * LANES + j;
                    if (pk < NPAR)
                        word_out[(LANES-1-j)*SYM_W +: SYM_W] = par_body[(NPAR-1-pk)*SYM_W +: SYM_W];
                end
            end
            default: begin
                word_out = '0;
            end
        endcase
    end

endmodule

// File: rtl/rs_stage_pipe.sv
module rs_stage_pipe #(
    parameter int W     = 33,
    parameter int DEPTH = 7
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);

    logic [DEPTH-1:0] v_q;
    logic [W-1:0]     d_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int k = 0; k < DEPTH; k++) d_q[k] <= '0;
        end else if (adv) begin
            v_q[0] <= in_v;
            d_q[0] <= in_d;
            for (int k = 1; k < DEPTH; k++) begin
                v_q[k] <= v_q[k-1];
                d_q[k] <= d_q[k-1];
            end
        end
    end

    assign out_v = v_q[DEPTH-1];
    assign out_d = d_q[DEPTH-1];

endmodule

// File: rtl/rs_stream_encoder.sv
module rs_stream_encoder
    import rs_enc_pkg::*;
#(
    parameter int         DATA_W     = 32,
    parameter int         CODE_N     = 255,
    parameter int         CODE_K     = 239,
    parameter int         FIRST_ROOT = 0,
    parameter logic [8:0] FIELD_POLY = 9'h187,
    parameter int         LATENCY    = 7
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast
);

    localparam int LANES     = DATA_W / SYM_W;
    localparam int NPAR      = CODE_N - CODE_K;
    localparam int IN_WORDS  = (CODE_K + LANES - 1) / LANES;
    localparam int TAIL_SYMS = CODE_K - (IN_WORDS - 1) * LANES;
    localparam int FILL      = LANES - TAIL_SYMS;
    localparam int PAR_WORDS = (NPAR - FILL + LANES - 1) / LANES;
    localparam int OUT_WORDS = IN_WORDS + PAR_WORDS;
    localparam int PAD_SYMS  = OUT_WORDS * LANES - CODE_N;
    localparam int IN_CW     = $clog2(IN_WORDS + 1);
    localparam int PAR_CW    = $clog2(PAR_WORDS + 1);
    localparam int OUT_CW    = $clog2(OUT_WORDS + 1);
    localparam int NW        = $clog2(LANES + 1);

    enc_state_e          state_q, state_d;
    logic [IN_CW-1:0]    in_cnt;
    logic [PAR_CW-1:0]   par_cnt;
    logic                advance;
    logic                accept;
    logic                last_in;
    logic                last_par;
    logic                push_v;
    logic                push_last;
    pack_mode_e          pk_mode;
    logic                lfsr_absorb;
    logic                lfsr_clr;
    logic [NW-1:0]       n_use;
    logic [NPAR*SYM_W-1:0] par_q;
    logic [NPAR*SYM_W-1:0] par_next;
    logic [DATA_W-1:0]   pk_word;
    logic [DATA_W:0]     pipe_out;

    assign advance  = !m_tvalid || m_tready;
    assign last_in  = (in_cnt == IN_CW'(IN_WORDS - 1));
    assign last_par = (par_cnt == PAR_CW'(PAR_WORDS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_DATA;
        else        state_q <= state_d;
    end

    // next state: DATA_TO_PARITY and PARITY_TO_DATA
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_DATA:   if (accept && last_in)   state_d = S_PARITY;
            S_PARITY: if (advance && last_par) state_d = S_DATA;
        endcase
    end

    // outputs of the controller
    always_comb begin
        s_tready    = 1'b0;
        push_v      = 1'b0;
        push_last   = 1'b0;
        pk_mode     = PK_PASS;
        lfsr_absorb = 1'b0;
        lfsr_clr    = 1'b0;
        n_use       = NW'(LANES);
        unique case (state_q)
            S_DATA: begin
                s_tready    = advance;
                push_v      = s_tvalid && advance;
                lfsr_absorb = s_tvalid && advance;
                pk_mode     = last_in ? PK_TAIL : PK_PASS;
                n_use       = last_in ? NW'(TAIL_SYMS) : NW'(LANES);
            end
            S_PARITY: begin
                push_v    = advance;
                push_last = last_par;
                pk_mode   = PK_PARITY;
                lfsr_clr  = advance && last_par;
            end
        endcase
    end

    assign accept = s_tvalid && s_tready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_cnt  <= '0;
            par_cnt <= '0;
        end else begin
            if (accept) in_cnt <= last_in ? '0 : in_cnt + 1'b1;
            if (state_q == S_PARITY && advance) par_cnt <= last_par ? '0 : par_cnt + 1'b1;
        end
    end

    rs_parity_lfsr #(
        .NPAR(NPAR), .LANES(LANES), .FIRST_ROOT(FIRST_ROOT), .POLY(FIELD_POLY)
    ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .absorb(lfsr_absorb), .clr(lfsr_clr),
        .word_in(s_tdata), .n_use(n_use), .par_q(par_q), .par_next(par_next)
    );

    rs_lane_packer #(
        .LANES(LANES), .NPAR(NPAR), .TAIL_SYMS(TAIL_SYMS), .IDX_W(PAR_CW)
    ) u_pack (
        .mode(pk_mode), .word_in(s_tdata), .par_tail(par_next), .par_body(par_q),
        .word_idx(par_cnt), .word_out(pk_word)
    );

    rs_stage_pipe #(.W(DATA_W + 1), .DEPTH(LATENCY)) u_pipe (
        .clk(clk), .rst_n(rst_n), .adv(advance), .in_v(push_v),
        .in_d({push_last, pk_word}), .out_v(m_tvalid), .out_d(pipe_out)
    );

    assign m_tlast = pipe_out[DATA_W];
    assign m_tdata = pipe_out[DATA_W-1:0];

    // independent counters for the checks below
    logic [OUT_CW-1:0] out_cnt;
    logic [IN_CW-1:0]  acc_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_cnt <= '0;
            acc_cnt <= '0;
        end else begin
            if (m_tvalid && m_tready)
                out_cnt <= (out_cnt == OUT_CW'(OUT_WORDS - 1)) ? '0 : out_cnt + 1'b1;
            if (s_tvalid && s_tready)
                acc_cnt <= (acc_cnt == IN_CW'(IN_WORDS - 1)) ? '0 : acc_cnt + 1'b1;
        end
    end

    // R5: the flag marks exactly the final word of each codeword
    a_r5_last_position: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready) |-> (m_tlast == (out_cnt == OUT_CW'(OUT_WORDS - 1))));

    // R8: a stalled output word holds still
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R6: input is refused right after the final information word
    a_r6_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready && acc_cnt == IN_CW'(IN_WORDS - 1)) |=> !s_tready);

    if (PAD_SYMS > 0) begin : g_pad_chk
        // R4: pad lanes of the final word are zero
        a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (m_tvalid && m_tlast) |-> (m_tdata[PAD_SYMS*SYM_W-1:0] == '0));
    end

endmodule

// File: tb/rs_stream_encoder_bench.sv
module rs_stream_encoder_bench;

    localparam int NIN  = 60;
    localparam int NOUT = 64;
    localparam int LAT  = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [31:0] m_tdata;
    logic        m_tvalid;
    logic        m_tready = 1'b0;
    logic        m_tlast;

    always #4 clk = ~clk;

    rs_stream_encoder u_rs_stream_encoder (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
    );

    int          n_total = 0;
    int          n_bad = 0;
    int          cyc = 0;
    bit          done = 0;
    logic [31:0] in_w  [NIN];
    logic [31:0] out_w [NOUT];
    logic        out_l [NOUT];
    logic [31:0] ref_w [NOUT];
    int          first_in, first_out, ready_low;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ x;
            x = x[7] ? ((x << 1) ^ 8'h87) : (x << 1);
        end
        return r;
    endfunction

    task automatic run_cw(input int vgap, input int rgap);
        int in_idx = 0;
        int out_idx = 0;
        int guard = 0;
        first_in = -1; first_out = -1; ready_low = 0;
        while (out_idx < NOUT && guard < 6000) begin
            @(negedge clk);
            m_tready = ($urandom_range(99) >= rgap);
            if (in_idx < NIN) begin
                s_tvalid = ($urandom_range(99) >= vgap);
                s_tdata  = in_w[in_idx];
            end else begin
                s_tvalid = 1'b0;
            end
            #1;
            if (in_idx == NIN && !s_tready) ready_low++;
            if (m_tvalid && m_tready) begin
                out_w[out_idx] = m_tdata;
                out_l[out_idx] = m_tlast;
                if (out_idx == 0) first_out = cyc + 1;
                out_idx++;
            end
            if (s_tvalid && s_tready) begin
                if (in_idx == 0) first_in = cyc + 1;
                in_idx++;
            end
            guard++;
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        m_tready = 1'b1;
        #1;
        check(out_idx == NOUT, "R4 watchdog word count", 32'(out_idx), 32'(NOUT));
        check(!m_tvalid, "R4 no extra word", 32'(m_tvalid), 32'd0);
        m_tready = 1'b0;
    endtask

    task automatic check_cw();
        logic [7:0] c [255];
        for (int w = 0; w < NIN - 1; w++)
            check(out_w[w] == in_w[w], "R1 pass-through", out_w[w], in_w[w]);
        check(out_w[NIN-1][31:8] == in_w[NIN-1][31:8], "R1 tail bytes",
              {8'h00, out_w[NIN-1][31:8]}, {8'h00, in_w[NIN-1][31:8]});
        for (int w = 0; w < NOUT; w++)
            check(out_l[w] == (w == NOUT - 1), "R5 tlast", 32'(out_l[w]), 32'(w == NOUT - 1));
        check(out_w[NOUT-1][7:0] == 8'h00, "R4 pad byte", 32'(out_w[NOUT-1][7:0]), 32'd0);
        for (int b = 0; b < 255; b++) c[b] = out_w[b/4][(3 - b%4)*8 +: 8];
        for (int r = 0; r < 16; r++) begin
            logic [7:0] a = 8'h01;
            logic [7:0] s = 8'h00;
            for (int e = 0; e < r; e++) a = fmul(a, 8'h02);
            for (int b = 0; b < 255; b++) s = fmul(s, a) ^ c[b];
            check(s == 8'h00, $sformatf("R3 syndrome %0d", r), 32'(s), 32'd0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(!m_tvalid, "R10 m_tvalid after reset", 32'(m_tvalid), 32'd0);
        check(s_tready, "R10 s_tready after reset", 32'(s_tready), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_counting();
        for (int i = 0; i < NIN; i++)
            in_w[i] = {8'(4*i), 8'(4*i+1), 8'(4*i+2), 8'(4*i+3)};
        run_cw(0, 0);
        check_cw();
        check(first_out - first_in == LAT, "R7 latency", 32'(first_out - first_in), 32'(LAT));
        check(ready_low == 4, "R6 ready low cycles", 32'(ready_low), 32'd4);
        for (int w = 0; w < NOUT; w++) ref_w[w] = out_w[w];
    endtask

    task automatic t_stalls();
        run_cw(35, 40);
        check_cw();
        for (int w = 0; w < NOUT; w++)
            check(out_w[w] == ref_w[w], "R8 R11 stalled stream", out_w[w], ref_w[w]);
    endtask

    task automatic t_ignore_low();
        in_w[NIN-1][7:0] = 8'h5A;
        run_cw(0, 0);
        for (int w = 0; w < NOUT; w++)
            check(out_w[w] == ref_w[w], "R2 low byte ignored", out_w[w], ref_w[w]);
        check(out_w[NIN-1][7:0] != 8'h5A, "R4 shared word carries parity",
              32'(out_w[NIN-1][7:0]), 32'h0);
    endtask

    task automatic t_clear();
        for (int i = 0; i < NIN; i++) in_w[i] = $urandom;
        run_cw(10, 10);
        check_cw();
        for (int i = 0; i < NIN; i++) in_w[i] = '0;
        run_cw(0, 0);
        for (int w = 0; w < NOUT; w++)
            check(out_w[w] == 32'h0, "R9 zero codeword", out_w[w], 32'h0);
    endtask

    task automatic t_random();
        for (int n = 0; n < 3; n++) begin
            for (int i = 0; i < NIN; i++) in_w[i] = $urandom;
            run_cw(20, 25);
            check_cw();
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_counting();
        t_stalls();
        t_ignore_low();
        t_clear();
        t_random();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule